// File: doc/BRIEF.md
# Triggered Sampling Acquisition Controller

This controller drives the address and control side of a multi-channel switched-capacitor sample store. While idle it writes continuously, moving the write address through a ring of cells by one cell on every main-clock cycle. A free-running coarse counter counts the same clock and supplies the event time stamp. A trigger from an external discriminator does not stop sampling at once. It loads a programmable delay, and writing goes on until that delay runs out.

When the delay expires, the controller stops writing. In the same clock edge it captures two values: the address of the oldest stored sample, called the stop address, and the coarse count of the last write cycle. It then reads back every cell of the ring, starting at the stop address. For each cell it runs a request/done handshake with a downstream ramp-type digitizer. After the last cell has been converted, it goes back to continuous writing without any outside action.

The state machine has four states. WRITE is idle sampling. DELAY counts down while still writing. CONV holds a convert request. GAP is a one-cycle pause between conversions. The transitions are:
- arm: WRITE to DELAY, on a trigger.
- halt: DELAY to CONV, when the count is zero.
- step: CONV to GAP, on done when cells remain.
- resume: GAP to CONV.
- finish: CONV to WRITE, on done for the last cell.

Top module: `trig_acq_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are as follows: `wr_addr_o`=0, `wr_en_o`=1, `busy_o`=0, `conv_req_o`=0, `stop_addr_o`=0 and `stamp_o`=0.
- R2: While not busy, `wr_en_o` is 1 and `wr_addr_o` advances once per clock. The next address after an address equal to or above `depth_cfg_i` (the last cell index, so the ring holds `depth_cfg_i`+1 cells) is 0. Otherwise the next address is the current one plus 1.
- R3: The coarse counter is 0 in the first cycle after reset and rises by 1 every clock. On a stop, `stamp_o` takes the counter value of the last write cycle.
- R4: A trigger sampled high in a non-busy cycle sets `busy_o` from the next cycle onward. Writing continues for exactly `dly_cfg_i`+1 cycles after the trigger cycle, and then `wr_en_o` falls.
- R5: On a stop, `stop_addr_o` and `wr_addr_o` both take the address that follows the last written cell, which is the oldest sample. `wr_addr_o` holds that value while writing is halted.
- R6: A trigger that arrives while `busy_o` is 1 has no effect on the stop timing, the stop address, the time stamp or the readout.
- R7: The read phase converts `depth_cfg_i`+1 cells. The first is at `stop_addr_o`, and the rest follow in ring order (modulo `depth_cfg_i`+1).
- R8: `conv_req_o` stays high with a stable `rd_addr_o` until `conv_done_i` is sampled high. It is then low for at least one cycle before the next request.
- R9: In the cycle after the last cell's done, `busy_o` is 0 and writing resumes from `stop_addr_o`.
- R10: `conv_req_o` is high only while `busy_o` is 1 and `wr_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| trig_i | input | 1 | discriminator trigger, sampled on the clock |
| dly_cfg_i | input | DLY_W | extra write cycles after a trigger, minus one |
| depth_cfg_i | input | ADDR_W | index of the last cell in the ring |
| wr_en_o | output | 1 | storage write enable |
| wr_addr_o | output | ADDR_W | cell being written |
| rd_addr_o | output | ADDR_W | cell being converted |
| conv_req_o | output | 1 | convert request to the digitizer |
| conv_done_i | input | 1 | digitizer finished the current cell |
| busy_o | output | 1 | event in progress (countdown or readout) |
| stop_addr_o | output | ADDR_W | oldest-sample address captured at stop |
| stamp_o | output | TS_W | coarse count captured at stop |

## Verification
The assertions assume that `depth_cfg_i` changes only while reset is asserted. They also assume that `conv_done_i` is raised only while a request is outstanding and only for a single cycle. The stimulus follows these rules. It changes the depth only inside a reset. Its digitizer model waits a random 0 to 3 cycles after seeing a request and then pulses done for exactly one cycle. Trigger noise is injected freely during the countdown and the readout, and that noise is what exercises the ignore rule.

// File: rtl/tac_pkg.sv
package tac_pkg;
    typedef enum logic [1:0] {
        ST_WRITE = 2'd0,
        ST_DELAY = 2'd1,
        ST_CONV  = 2'd2,
        ST_GAP   = 2'd3
    } tac_state_e;
endpackage

// File: rtl/tac_wr_seq.sv
module tac_wr_seq #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_o
);
    // ring successor; an address beyond the last index also wraps
    assign next_o = (addr_o >= last_i) ? '0 : addr_o + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_o <= '0;
        else if (adv_i) addr_o <= next_o;
    end
endmodule

// File: rtl/tac_dly_cnt.sv
module tac_dly_cnt #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= val_i;
        else if (dec_i)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tac_rd_seq.sv
module tac_rd_seq #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] last_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              final_o
);
    logic [ADDR_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            left_q <= '0;
        end else if (start_i) begin
            addr_o <= start_addr_i;
            left_q <= last_i;
        end else if (adv_i) begin
            addr_o <= (addr_o >= last_i) ? '0 : addr_o + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign final_o = (left_q == '0);
endmodule

// File: rtl/trig_acq_ctrl.sv
module trig_acq_ctrl
    import tac_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DLY_W  = 8,
    parameter int TS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [DLY_W-1:0]  dly_cfg_i,
    input  logic [ADDR_W-1:0] depth_cfg_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              conv_req_o,
    input  logic              conv_done_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] stop_addr_o,
    output logic [TS_W-1:0]   stamp_o
);
    tac_state_e        state_q, state_d;
    logic [TS_W-1:0]   coarse_q;
    logic [ADDR_W-1:0] wr_next;
    logic              dly_load, dly_dec, dly_zero;
    logic              halt, rd_adv, rd_final;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WRITE;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        dly_load = 1'b0;
        dly_dec  = 1'b0;
        halt     = 1'b0;
        rd_adv   = 1'b0;
        unique case (state_q)
            ST_WRITE: if (trig_i) begin
                state_d  = ST_DELAY;
                dly_load = 1'b1;
            end
            ST_DELAY: if (dly_zero) begin
                state_d = ST_CONV;
                halt    = 1'b1;
            end else begin
                dly_dec = 1'b1;
            end
            ST_CONV: if (conv_done_i) begin
                if (rd_final) begin
                    state_d = ST_WRITE;
                end else begin
                    state_d = ST_GAP;
                    rd_adv  = 1'b1;
                end
            end
            ST_GAP: state_d = ST_CONV;
        endcase
    end

    // outputs
    always_comb begin
        wr_en_o    = (state_q == ST_WRITE) || (state_q == ST_DELAY);
        busy_o     = (state_q != ST_WRITE);
        conv_req_o = (state_q == ST_CONV);
    end

    // coarse time base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coarse_q <= '0;
        else        coarse_q <= coarse_q + 1'b1;
    end

    // stop capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_addr_o <= '0;
            stamp_o     <= '0;
        end else if (halt) begin
            stop_addr_o <= wr_next;
            stamp_o     <= coarse_q;
        end
    end

    tac_wr_seq #(.ADDR_W(ADDR_W)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (wr_en_o),
        .last_i (depth_cfg_i),
        .addr_o (wr_addr_o),
        .next_o (wr_next)
    );

    tac_dly_cnt #(.DLY_W(DLY_W)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dly_load),
        .val_i  (dly_cfg_i),
        .dec_i  (dly_dec),
        .zero_o (dly_zero)
    );

    tac_rd_seq #(.ADDR_W(ADDR_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (halt),
        .start_addr_i (wr_next),
        .last_i       (depth_cfg_i),
        .adv_i        (rd_adv),
        .addr_o       (rd_addr_o),
        .final_o      (rd_final)
    );
endmodule

// File: rtl/tac_chk.sv
module tac_chk #(
    parameter int ADDR_W = 6,
    parameter int DLY_W  = 8,
    parameter int TS_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic [DLY_W-1:0]  dly_cfg_i,
    input logic [ADDR_W-1:0] depth_cfg_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              conv_req_o,
    input logic              conv_done_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] stop_addr_o,
    input logic [TS_W-1:0]   stamp_o
);
    // R2
    wr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o <= depth_cfg_i));

    // R2
    idle_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> wr_en_o);

    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |=> (wr_addr_o == $past(wr_addr_o)));

    // R3
    stamp_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_o != $past(stamp_o)) |-> $fell(wr_en_o));

    // R4
    arm_keeps_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> wr_en_o);

    // R7
    rd_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (rd_addr_o <= depth_cfg_i));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && !conv_done_i) |=> (conv_req_o && $stable(rd_addr_o)));

    // R8
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req_o && conv_done_i) |=> !conv_req_o);

    // R10
    req_only_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |-> (busy_o && !wr_en_o));
endmodule

bind trig_acq_ctrl tac_chk #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .TS_W(TS_W)) u_chk (.*);

// File: tb/trig_acq_ctrl_tb.sv
`timescale 1ns/1ps
module trig_acq_ctrl_tb;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic [DW-1:0] dly = '0;
    logic [AW-1:0] depth = '0;
    logic          wr_en, req, done = 1'b0, busy;
    logic [AW-1:0] wr_addr, rd_addr, stop_addr;
    logic [TW-1:0] stamp;

    int checks = 0;
    int fails = 0;
    int exp_wa = 0;
    int exp_coarse = 0;
    bit exp_wr = 1'b1;

    always #2 clk = ~clk;

    trig_acq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .dly_cfg_i(dly),
        .depth_cfg_i(depth), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .rd_addr_o(rd_addr), .conv_req_o(req), .conv_done_i(done),
        .busy_o(busy), .stop_addr_o(stop_addr), .stamp_o(stamp)
    );

    function automatic int nxt(input int a, input int last);
        return (a >= last) ? 0 : a + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: model update at the edge, check away from it
    task automatic step();
        @(posedge clk);
        if (exp_wr) exp_wa = nxt(exp_wa, int'(depth));
        exp_coarse++;
        @(negedge clk);
        chk(int'(wr_addr) == exp_wa, "R2/R5 wr_addr", int'(wr_addr), exp_wa);
    endtask

    task automatic do_reset(input int last);
        @(negedge clk);
        rst_n = 1'b0;
        depth = AW'(last);
        trig  = 1'b0;
        done  = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_addr == 0 && wr_en && !busy && !req, "R1 reset ctl",
            {wr_en, busy, req}, 3'b100);
        chk(stop_addr == 0 && stamp == 0, "R1 reset capture", int'(stamp), 0);
        rst_n      = 1'b1;
        exp_wa     = 0;
        exp_coarse = 0;
        exp_wr     = 1'b1;
    endtask

    task automatic run_event(input int d, input bit noisy);
        int last;
        int exp_stop;
        int exp_stamp;
        int idle;
        last = int'(depth);
        idle = $urandom_range(0, 40);
        exp_stop = 0;
        exp_stamp = 0;
        for (int i = 0; i < idle; i++) begin
            step();
            chk(wr_en && !busy, "R2 idle writing", {wr_en, busy}, 2'b10);
        end
        dly  = DW'(d);
        trig = 1'b1;
        step();
        trig = 1'b0;
        chk(busy == 1'b1, "R4 busy after trigger", busy, 1);
        for (int i = 0; i <= d; i++) begin
            chk(wr_en == 1'b1, "R4 still writing", wr_en, 1);
            if (noisy) trig = 1'($urandom_range(0, 1));
            if (i == d) begin
                exp_stamp = exp_coarse;
                exp_stop  = nxt(exp_wa, last);
            end
            step();
            trig = 1'b0;
        end
        exp_wr = 1'b0;
        chk(wr_en == 1'b0, "R4 write halted", wr_en, 0);
        chk(int'(stop_addr) == exp_stop, "R5/R6 stop_addr", int'(stop_addr), exp_stop);
        chk(int'(stamp) == exp_stamp, "R3/R6 stamp", int'(stamp), exp_stamp);
        for (int c = 0; c <= last; c++) begin
            int n;
            int lat;
            int ea;
            n = 0;
            while (!req && n < 8) begin
                if (noisy) trig = 1'($urandom_range(0, 1));
                step();
                trig = 1'b0;
                n++;
            end
            ea = (exp_stop + c) % (last + 1);
            chk(req == 1'b1, "R8 request seen", req, 1);
            chk(int'(rd_addr) == ea, "R7 read order", int'(rd_addr), ea);
            chk(busy && !wr_en, "R10 read phase", {busy, wr_en}, 2'b10);
            lat = $urandom_range(0, 3);
            for (int k = 0; k < lat; k++) begin
                if (noisy) trig = 1'($urandom_range(0, 1));
                step();
                trig = 1'b0;
                chk(req && int'(rd_addr) == ea, "R8 request held", int'(rd_addr), ea);
            end
            done = 1'b1;
            step();
            done = 1'b0;
            if (c < last) begin
                chk(req == 1'b0, "R8 gap after done", req, 0);
            end else begin
                chk(!busy && wr_en, "R9 back to writing", {busy, wr_en}, 2'b01);
                chk(int'(wr_addr) == exp_stop, "R9 resume addr", int'(wr_addr), exp_stop);
                exp_wr = 1'b1;
            end
        end
        step();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        do_reset(7);
        run_event(0, 1'b0);
        run_event(3, 1'b1);
        do_reset(0);
        run_event(2, 1'b1);
        run_event(0, 1'b1);
        do_reset(63);
        run_event(255, 1'b1);
        do_reset(5);
        run_event(1, 1'b0);
        for (int r = 0; r < 6; r++) begin
            do_reset($urandom_range(0, 20));
            run_event($urandom_range(0, 30), 1'b1);
            run_event($urandom_range(0, 30), 1'b1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule